// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This controller steps a device between four power modes: active, idle, standby and shutdown. Software asks for a low-power mode with a one-cycle request strobe. The block then drives one enable per domain: CPU clock, memory clock, peripheral clocks, radio, high-speed clock, the always-on domain and the co-processor. It also drives one level that puts the brown-out detector into duty-cycled operation. Each low-power mode has its own set of wake sources. When a valid wake source arrives, the block switches every domain back on. It then counts a programmable latency in low-speed clock ticks before it raises `active_ready`.

Leaving idle or standby is a resume. Leaving shutdown is a full restart. In that case the block sends a one-cycle reset request, and all of its latency registers go back to their power-on defaults. Oscillators, supplies and the CPU are outside the block. They appear only as the enables it drives.

Top module: `pwr_seq_top`

## Requirements
- R1: After power-on reset the block is in active mode with every enable high, `bod_duty` low, `reset_req` low and `active_ready` high. The latency registers hold their defaults: idle 1, standby 6, shutdown 34 ticks.
- R2: In active mode, a cycle with `req_valid` high selects a new mode from `req_mode`, which takes effect from the next cycle. The encoding is 0 active, 1 idle, 2 standby, 3 shutdown.
- R3: A request is ignored when it arrives in idle, standby, shutdown or a wake-up countdown. Once the countdown ends the block stays in active mode.
- R4: In idle, `cpu_clk_en` and `mem_clk_en` are low and `per_clk_en`, `radio_en`, `hf_clk_en`, `aon_en`, `cop_en` are high. `bod_duty` and `active_ready` are low.
- R5: Idle is left on any of `irq`, `rtc_evt`, `pin_wake` or `cop_evt`. The countdown uses the idle latency register.
- R6: In standby only `aon_en` and `cop_en` are high, `bod_duty` is high, and every other enable and `active_ready` is low.
- R7: Standby ignores `irq`. It is left on `rtc_evt`, `pin_wake` or `cop_evt`, and the countdown uses the standby latency register.
- R8: In shutdown every output is low, including `aon_en` and `cop_en`. Only `pin_wake` or `rst_pin` leaves shutdown; `irq`, `rtc_evt` and `cop_evt` are ignored.
- R9: Leaving shutdown does three things. It pulses `reset_req` high for exactly the first countdown cycle. It counts the shutdown latency register. It returns all latency registers to their defaults.
- R10: During a countdown all enables are high and `active_ready` is low. With a latency of L, active mode begins on the cycle after the cycle that carries the L-th `lf_tick`. With L = 0, active mode begins one cycle after the countdown starts.
- R11: A cycle with `lat_we` high writes `lat_val` into the register chosen by `lat_sel` (0 idle, 1 standby, 2 shutdown; 3 writes nothing). If that write coincides with a wake that uses the same register, the wake counts the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| lf_tick | input | 1 | One-cycle pulse per low-speed clock period |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode |
| irq | input | 1 | Ordinary interrupt |
| rtc_evt | input | 1 | Real-time-clock event |
| pin_wake | input | 1 | External pin wake event |
| cop_evt | input | 1 | Co-processor wake event |
| rst_pin | input | 1 | External reset pin event |
| lat_we | input | 1 | Latency register write strobe |
| lat_sel | input | 2 | Latency register select |
| lat_val | input | LAT_W | Latency value in low-speed ticks |
| cpu_clk_en | output | 1 | CPU clock enable |
| mem_clk_en | output | 1 | Memory clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| radio_en | output | 1 | Radio enable |
| hf_clk_en | output | 1 | High-speed clock enable |
| bod_duty | output | 1 | Brown-out detector duty-cycled |
| aon_en | output | 1 | Always-on domain enable |
| cop_en | output | 1 | Co-processor enable |
| active_ready | output | 1 | CPU running in active mode |
| reset_req | output | 1 | Full reset request after shutdown wake |

## Verification
Two events can fall in the same cycle: a latency register write, and a wake that loads the countdown from that same register. The bench provokes this by raising `cop_evt` in idle together with a write of 3 to the idle latency register. It then judges the result from `active_ready`, which must stay low through two ticks and rise only after the third. A second coincidence is a shutdown wake, which reloads the register defaults while it loads the countdown. The bench checks that the programmed shutdown latency is the one counted, and that a later idle wake counts the default instead of the value written earlier.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_IDLE,
    ST_STANDBY,
    ST_SHUTDOWN,
    ST_WAKE
  } pwr_state_e;

  localparam logic [1:0] MODE_ACTIVE   = 2'd0;
  localparam logic [1:0] MODE_IDLE     = 2'd1;
  localparam logic [1:0] MODE_STANDBY  = 2'd2;
  localparam logic [1:0] MODE_SHUTDOWN = 2'd3;

  localparam logic [1:0] LSEL_IDLE  = 2'd0;
  localparam logic [1:0] LSEL_STBY  = 2'd1;
  localparam logic [1:0] LSEL_SHDN  = 2'd2;
  localparam int         LAT_NSRC   = 3;

  typedef struct packed {
    logic cpu;
    logic mem;
    logic per;
    logic radio;
    logic hf;
    logic bod_duty;
    logic aon;
    logic cop;
  } gate_map_t;

endpackage

// File: rtl/pwr_seq_wake.sv
module pwr_seq_wake
  import pwr_seq_pkg::*;
(
  input  pwr_state_e state,
  input  logic       irq,
  input  logic       rtc_evt,
  input  logic       pin_wake,
  input  logic       cop_evt,
  input  logic       rst_pin,
  output logic       wake_hit,
  output logic       wake_shd,
  output logic [1:0] wake_sel
);

  // Each low-power mode qualifies its own subset of wake sources.
  always_comb begin
    wake_hit = 1'b0;
    wake_shd = 1'b0;
    wake_sel = LSEL_IDLE;
    unique case (state)
      ST_IDLE: begin
        wake_hit = irq | rtc_evt | pin_wake | cop_evt;
        wake_sel = LSEL_IDLE;
      end
      ST_STANDBY: begin
        wake_hit = rtc_evt | pin_wake | cop_evt;
        wake_sel = LSEL_STBY;
      end
      ST_SHUTDOWN: begin
        wake_hit = pin_wake | rst_pin;
        wake_shd = pin_wake | rst_pin;
        wake_sel = LSEL_SHDN;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pwr_seq_lat.sv
module pwr_seq_lat
  import pwr_seq_pkg::*;
#(
  parameter int LAT_W    = 8,
  parameter int DEF_IDLE = 1,
  parameter int DEF_STBY = 6,
  parameter int DEF_SHDN = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_we,
  input  logic [1:0]       lat_sel,
  input  logic [LAT_W-1:0] lat_val,
  input  logic             load,
  input  logic [1:0]       load_sel,
  input  logic             restore,
  input  logic             counting,
  input  logic             lf_tick,
  output logic             done
);

  localparam logic [LAT_W-1:0] DEF_VAL [LAT_NSRC] =
    '{LAT_W'(DEF_IDLE), LAT_W'(DEF_STBY), LAT_W'(DEF_SHDN)};

  logic [LAT_W-1:0] lat_q [LAT_NSRC];
  logic [LAT_W-1:0] cnt_q, cnt_d, ld_val, sel_val;
  logic             cnt_en;

  for (genvar g = 0; g < LAT_NSRC; g++) begin : g_latreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                lat_q[g] <= DEF_VAL[g];
      else if (restore)                          lat_q[g] <= DEF_VAL[g];
      else if (lat_we && (lat_sel == 2'(g)))     lat_q[g] <= lat_val;
    end
  end

  always_comb begin
    unique case (load_sel)
      LSEL_IDLE: sel_val = lat_q[0];
      LSEL_STBY: sel_val = lat_q[1];
      LSEL_SHDN: sel_val = lat_q[2];
      default:   sel_val = '0;
    endcase
    // A write to the register being loaded is forwarded to the counter.
    ld_val = (lat_we && (lat_sel == load_sel)) ? lat_val : sel_val;
  end

  always_comb begin
    cnt_en = load | (counting & lf_tick & (cnt_q != '0));
    cnt_d  = load ? ld_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R10: once counting, the remaining count never grows until the next load.
  a_r10_cnt_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !load) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/pwr_seq_gate.sv
module pwr_seq_gate
  import pwr_seq_pkg::*;
(
  input  pwr_state_e state,
  output gate_map_t  gmap
);

  always_comb begin
    unique case (state)
      ST_ACTIVE, ST_WAKE:
        gmap = '{cpu:1'b1, mem:1'b1, per:1'b1, radio:1'b1, hf:1'b1,
                 bod_duty:1'b0, aon:1'b1, cop:1'b1};
      ST_IDLE:
        gmap = '{cpu:1'b0, mem:1'b0, per:1'b1, radio:1'b1, hf:1'b1,
                 bod_duty:1'b0, aon:1'b1, cop:1'b1};
      ST_STANDBY:
        gmap = '{cpu:1'b0, mem:1'b0, per:1'b0, radio:1'b0, hf:1'b0,
                 bod_duty:1'b1, aon:1'b1, cop:1'b1};
      default:
        gmap = '0;
    endcase
  end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int LAT_W    = 8,
  parameter int DEF_IDLE = 1,
  parameter int DEF_STBY = 6,
  parameter int DEF_SHDN = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lf_tick,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic             irq,
  input  logic             rtc_evt,
  input  logic             pin_wake,
  input  logic             cop_evt,
  input  logic             rst_pin,
  input  logic             lat_we,
  input  logic [1:0]       lat_sel,
  input  logic [LAT_W-1:0] lat_val,
  output logic             cpu_clk_en,
  output logic             mem_clk_en,
  output logic             per_clk_en,
  output logic             radio_en,
  output logic             hf_clk_en,
  output logic             bod_duty,
  output logic             aon_en,
  output logic             cop_en,
  output logic             active_ready,
  output logic             reset_req
);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  pwr_state_e state_q, state_d;
  logic       wake_hit, wake_shd, lat_done;
  logic [1:0] wake_sel;
  gate_map_t  gmap;
  logic       rreq_q;

  pwr_seq_wake u_wake (
    .state    (state_q),
    .irq      (irq),
    .rtc_evt  (rtc_evt),
    .pin_wake (pin_wake),
    .cop_evt  (cop_evt),
    .rst_pin  (rst_pin),
    .wake_hit (wake_hit),
    .wake_shd (wake_shd),
    .wake_sel (wake_sel)
  );

  pwr_seq_lat #(
    .LAT_W    (LAT_W),
    .DEF_IDLE (DEF_IDLE),
    .DEF_STBY (DEF_STBY),
    .DEF_SHDN (DEF_SHDN)
  ) u_lat (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .lat_we   (lat_we),
    .lat_sel  (lat_sel),
    .lat_val  (lat_val),
    .load     (wake_hit),
    .load_sel (wake_sel),
    .restore  (wake_shd),
    .counting (state_q == ST_WAKE),
    .lf_tick  (lf_tick),
    .done     (lat_done)
  );

  pwr_seq_gate u_gate (
    .state (state_q),
    .gmap  (gmap)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (req_valid) begin
          unique case (req_mode)
            MODE_IDLE:     state_d = ST_IDLE;
            MODE_STANDBY:  state_d = ST_STANDBY;
            MODE_SHUTDOWN: state_d = ST_SHUTDOWN;
            default:       state_d = ST_ACTIVE;
          endcase
        end
      end
      ST_IDLE, ST_STANDBY, ST_SHUTDOWN: begin
        if (wake_hit) state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (lat_done) state_d = ST_ACTIVE;
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_ACTIVE;
      rreq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rreq_q  <= wake_shd;
    end
  end

  assign cpu_clk_en   = gmap.cpu;
  assign mem_clk_en   = gmap.mem;
  assign per_clk_en   = gmap.per;
  assign radio_en     = gmap.radio;
  assign hf_clk_en    = gmap.hf;
  assign bod_duty     = gmap.bod_duty;
  assign aon_en       = gmap.aon;
  assign cop_en       = gmap.cop;
  assign active_ready = (state_q == ST_ACTIVE);
  assign reset_req    = rreq_q;

  // R3: without a qualified wake a low-power mode holds, whatever is requested.
  a_r3_req_ignored: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((state_q == ST_IDLE || state_q == ST_STANDBY || state_q == ST_SHUTDOWN) && !wake_hit)
    |=> (state_q == $past(state_q)));

  // R7: an ordinary interrupt alone never leaves standby.
  a_r7_irq_no_stby_exit: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_STANDBY && !rtc_evt && !pin_wake && !cop_evt) |=> (state_q == ST_STANDBY));

  // R8: shutdown keeps the always-on domain and co-processor dark.
  a_r8_shd_dark: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_SHUTDOWN) |-> (!aon_en && !cop_en && !cpu_clk_en && !active_ready));

  // R9: a reset request only follows a shutdown exit.
  a_r9_reset_after_shd: assert property (@(posedge clk) disable iff (!rst_s_n)
    reset_req |-> ($past(state_q) == ST_SHUTDOWN && state_q == ST_WAKE));

  // R10: the CPU is not reported running while the countdown is still busy.
  a_r10_ready_waits: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_WAKE && !lat_done) |=> !active_ready);

  // R6: duty-cycled brown-out detection only with high-speed clock off.
  a_r6_bod_duty_map: assert property (@(posedge clk) disable iff (!rst_s_n)
    bod_duty |-> (!hf_clk_en && !radio_en && aon_en));

endmodule

// File: tb/pwr_seq_top_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_top_tb_top;

  localparam int LAT_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, lf_tick, req_valid, irq, rtc_evt, pin_wake, cop_evt, rst_pin, lat_we;
  logic [1:0] req_mode, lat_sel;
  logic [LAT_W-1:0] lat_val;
  logic cpu_clk_en, mem_clk_en, per_clk_en, radio_en, hf_clk_en, bod_duty;
  logic aon_en, cop_en, active_ready, reset_req;

  pwr_seq_top #(.LAT_W(LAT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .req_valid(req_valid),
    .req_mode(req_mode), .irq(irq), .rtc_evt(rtc_evt), .pin_wake(pin_wake),
    .cop_evt(cop_evt), .rst_pin(rst_pin), .lat_we(lat_we), .lat_sel(lat_sel),
    .lat_val(lat_val), .cpu_clk_en(cpu_clk_en), .mem_clk_en(mem_clk_en),
    .per_clk_en(per_clk_en), .radio_en(radio_en), .hf_clk_en(hf_clk_en),
    .bod_duty(bod_duty), .aon_en(aon_en), .cop_en(cop_en),
    .active_ready(active_ready), .reset_req(reset_req)
  );

  // {cpu, mem, per, radio, hf, bod_duty, aon, cop, active_ready, reset_req}
  localparam logic [9:0] V_ACT  = 10'b11111_0_11_1_0;
  localparam logic [9:0] V_WAKE = 10'b11111_0_11_0_0;
  localparam logic [9:0] V_WRST = 10'b11111_0_11_0_1;
  localparam logic [9:0] V_IDLE = 10'b00111_0_11_0_0;
  localparam logic [9:0] V_STBY = 10'b00000_1_11_0_0;
  localparam logic [9:0] V_SHD  = 10'b00000_0_00_0_0;

  typedef struct {
    string      tag;
    logic [9:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_total = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  wire [9:0] obs = {cpu_clk_en, mem_clk_en, per_clk_en, radio_en, hf_clk_en,
                    bod_duty, aon_en, cop_en, active_ready, reset_req};

  // Monitor: pops every expectation pushed at this falling edge.
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_total++;
      if (obs !== it.exp) begin
        n_fail++;
        $display("FAIL %s: outputs %b expected %b", it.tag, obs, it.exp);
      end
    end
  end

  task automatic expect_out(input string tag, input logic [9:0] v);
    sb_q.push_back('{tag, v});
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      lf_tick = 1'b1; cyc(); lf_tick = 1'b0;
    end
  endtask

  task automatic request(input logic [1:0] m);
    req_valid = 1'b1; req_mode = m; cyc(); req_valid = 1'b0;
  endtask

  task automatic write_lat(input logic [1:0] s, input logic [LAT_W-1:0] v);
    lat_we = 1'b1; lat_sel = s; lat_val = v; cyc(); lat_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done_flag) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: outputs %b expected completion", obs);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; lf_tick = 0; req_valid = 0; req_mode = 0; irq = 0; rtc_evt = 0;
    pin_wake = 0; cop_evt = 0; rst_pin = 0; lat_we = 0; lat_sel = 0; lat_val = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    expect_out("R1 reset state", V_ACT);

    request(2'd1);
    expect_out("R2 R4 enter idle", V_IDLE);
    request(2'd2);
    expect_out("R3 request in idle ignored", V_IDLE);

    irq = 1'b1; cyc(); irq = 1'b0;
    expect_out("R5 irq wakes idle", V_WAKE);
    tick();
    expect_out("R10 default idle latency counting", V_WAKE);
    cyc();
    expect_out("R10 R1 active after one tick", V_ACT);

    lat_we = 1'b1; lat_sel = 2'd0; lat_val = 8'd0;
    request(2'd1);
    lat_we = 1'b0;
    expect_out("R2 idle again", V_IDLE);
    rtc_evt = 1'b1; cyc(); rtc_evt = 1'b0;
    expect_out("R5 rtc wakes idle", V_WAKE);
    cyc();
    expect_out("R10 zero latency", V_ACT);

    request(2'd1);
    expect_out("R4 idle map", V_IDLE);
    cop_evt = 1'b1; lat_we = 1'b1; lat_sel = 2'd0; lat_val = 8'd3;
    cyc();
    cop_evt = 1'b0; lat_we = 1'b0;
    expect_out("R11 same-cycle write and wake", V_WAKE);
    tick(2);
    expect_out("R11 forwarded latency still counting", V_WAKE);
    tick();
    expect_out("R11 third tick", V_WAKE);
    cyc();
    expect_out("R11 active after forwarded count", V_ACT);

    request(2'd2);
    expect_out("R6 standby map", V_STBY);
    irq = 1'b1; cyc(); irq = 1'b0;
    expect_out("R7 irq ignored in standby", V_STBY);
    pin_wake = 1'b1; cyc(); pin_wake = 1'b0;
    expect_out("R7 pin wakes standby", V_WAKE);
    request(2'd3);
    tick(5);
    expect_out("R10 R1 standby default five ticks", V_WAKE);
    tick();
    expect_out("R10 sixth tick", V_WAKE);
    cyc();
    expect_out("R10 active after standby latency", V_ACT);
    cyc();
    expect_out("R3 request during countdown ignored", V_ACT);

    write_lat(2'd2, 8'd2);
    write_lat(2'd0, 8'd5);
    write_lat(2'd3, 8'd9);
    request(2'd3);
    expect_out("R8 shutdown map", V_SHD);
    rtc_evt = 1'b1; irq = 1'b1; cop_evt = 1'b1; cyc();
    rtc_evt = 1'b0; irq = 1'b0; cop_evt = 1'b0;
    expect_out("R8 rtc irq cop ignored in shutdown", V_SHD);
    pin_wake = 1'b1; cyc(); pin_wake = 1'b0;
    expect_out("R9 reset request on shutdown wake", V_WRST);
    tick();
    expect_out("R9 reset request one cycle", V_WAKE);
    tick();
    expect_out("R9 programmed shutdown latency", V_WAKE);
    cyc();
    expect_out("R9 active after shutdown latency", V_ACT);

    request(2'd1);
    irq = 1'b1; cyc(); irq = 1'b0;
    expect_out("R9 idle wake after restart", V_WAKE);
    tick();
    expect_out("R9 idle latency restored", V_WAKE);
    cyc();
    expect_out("R9 default idle latency used", V_ACT);

    request(2'd3);
    expect_out("R8 shutdown again", V_SHD);
    rst_pin = 1'b1; cyc(); rst_pin = 1'b0;
    expect_out("R8 reset pin leaves shutdown", V_WRST);

    cyc(2);
    done_flag = 1'b1;
    finish_run();
  end

endmodule